// File: doc/BRIEF.md
# Float-Integer Conversion Unit

This unit converts between IEEE-754 single-precision values and signed 32-bit integers. A caller presents a 32-bit operand together with a 4-bit major code and a 4-bit minor code, and pulses `start`. Exactly one clock later the unit raises `done` for one cycle, with the converted value on `result` and two exception flags. `invalid` marks a NaN or an out-of-range source. `inexact` marks a value that had to be rounded.

In the float-to-integer direction, the code pair chooses the rounding direction per operation. The choices are nearest, toward zero, toward plus infinity and toward minus infinity, plus a variant that uses the default mode. The default mode is round-to-nearest with ties to even. The integer-to-float direction always uses the default mode.

Control is a two-state machine.
- `ST_IDLE` waits for work.
- `ST_DONE` is the cycle in which `done` is high.

It has three transitions.
- *launch*: `ST_IDLE` to `ST_DONE` when `start` is high.
- *chain*: `ST_DONE` to `ST_DONE` when a new `start` arrives while the previous result is being delivered.
- *retire*: `ST_DONE` to `ST_IDLE` when no new `start` arrives.

The output registers load on every `start` and hold their value otherwise.

Top module: `fcu_top`

## Requirements
- R1: `done` is high in the cycle after each cycle in which `start` was high, and low in the cycle after a cycle without `start`; back-to-back starts keep `done` high with a fresh result each cycle.
- R2: With minor code 0x0, major code 0xC converts float to integer rounding to nearest (ties to even), 0xD truncates toward zero, 0xE rounds toward plus infinity and 0xF rounds toward minus infinity.
- R3: Major 0x4 with minor 0x1 converts float to integer in the default mode, round-to-nearest with ties to even.
- R4: Major 0x0 with minor 0x9 converts a signed 32-bit integer to single precision, rounding to nearest with ties to even. Integer zero gives +0.0 (0x00000000), and every magnitude up to 2^24 is exact. The conversion never raises `invalid`.
- R5: A float-to-integer result is the two's-complement value of the rounded operand; -0.0 and subnormals that round to zero give 0.
- R6: A NaN operand of either sign to any float-to-integer code raises `invalid` and gives 0x80000000.
- R7: A float-to-integer source at or above 2^31, including +infinity, raises `invalid` and gives 0x7FFFFFFF. A source below -2^31, including -infinity, raises `invalid` and gives 0x80000000. Exactly -2^31 converts to 0x80000000 with no flag.
- R8: `inexact` is high exactly when nonzero fraction bits were discarded; it is low whenever `invalid` is high.
- R9: Any other code pair gives result 0 with both flags low.
- R10: `result`, `invalid` and `inexact` keep their values until the next `start`, whatever the other inputs do.
- R11: After reset `done`, `result`, `invalid` and `inexact` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion of the operand under the code pair |
| major | input | 4 | Major operation code |
| minor | input | 4 | Minor operation code |
| operand | input | 32 | Float bit pattern or signed integer source |
| result | output | 32 | Converted value, held until the next start |
| done | output | 1 | One-cycle strobe, result valid |
| invalid | output | 1 | NaN or out-of-range source |
| inexact | output | 1 | Rounding discarded nonzero bits |

## Verification
Delivery of one result and acceptance of the next can fall in the same cycle. This happens when `start` is held high across consecutive clocks, so the *chain* transition is taken while `done` is already high. The bench provokes it with three code pairs issued back to back: a float-to-integer rounding, an integer-to-float rounding and an unsupported pair. It judges each cycle by checking that `done` stays high and that each result and flag set belongs to its own operation and not to the one before it. After `start` drops, the bench checks that `done` falls and that the last result stays unchanged while the inputs keep changing.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
    // Format geometry
    localparam int FP_W   = 32;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = FP_W - EXP_W - 1;
    localparam int SIG_W  = MAN_W + 1;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int INT_W  = 32;
    localparam int CODE_W = 4;

    localparam logic [INT_W-1:0] INT_MOST_NEG = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] INT_MOST_POS = {1'b0, {(INT_W-1){1'b1}}};

    // Code pairs {major, minor}
    localparam logic [2*CODE_W-1:0] PAIR_F2I_NEAR = 8'hC0;
    localparam logic [2*CODE_W-1:0] PAIR_F2I_ZERO = 8'hD0;
    localparam logic [2*CODE_W-1:0] PAIR_F2I_UP   = 8'hE0;
    localparam logic [2*CODE_W-1:0] PAIR_F2I_DOWN = 8'hF0;
    localparam logic [2*CODE_W-1:0] PAIR_F2I_DFLT = 8'h41;
    localparam logic [2*CODE_W-1:0] PAIR_I2F_DFLT = 8'h09;

    typedef enum logic [1:0] {RND_NEAR, RND_ZERO, RND_UP, RND_DOWN} rnd_e;
    typedef enum logic [1:0] {OP_NONE, OP_F2I, OP_I2F} op_e;
    typedef enum logic       {ST_IDLE, ST_DONE} fsm_e;

    typedef struct packed {
        op_e  op;
        rnd_e rnd;
    } cmd_t;
endpackage

// File: rtl/fcu_decode.sv
module fcu_decode
    import fcu_pkg::*;
#(
    parameter rnd_e DEFAULT_RND = RND_NEAR
) (
    input  logic [CODE_W-1:0] major,
    input  logic [CODE_W-1:0] minor,
    output cmd_t              cmd
);
    always_comb begin
        cmd.op  = OP_NONE;
        cmd.rnd = DEFAULT_RND;
        case ({major, minor})
            PAIR_F2I_NEAR: begin cmd.op = OP_F2I; cmd.rnd = RND_NEAR; end
            PAIR_F2I_ZERO: begin cmd.op = OP_F2I; cmd.rnd = RND_ZERO; end
            PAIR_F2I_UP:   begin cmd.op = OP_F2I; cmd.rnd = RND_UP;   end
            PAIR_F2I_DOWN: begin cmd.op = OP_F2I; cmd.rnd = RND_DOWN; end
            PAIR_F2I_DFLT: begin cmd.op = OP_F2I; cmd.rnd = DEFAULT_RND; end
            PAIR_I2F_DFLT: begin cmd.op = OP_I2F; cmd.rnd = DEFAULT_RND; end
            default:       begin cmd.op = OP_NONE; end
        endcase
    end
endmodule

// File: rtl/fcu_f2i.sv
module fcu_f2i
    import fcu_pkg::*;
(
    input  logic [FP_W-1:0]  src,
    input  rnd_e             rnd,
    output logic [INT_W-1:0] res,
    output logic             inv,
    output logic             inx
);
    // Guard region wide enough that a clamped shift leaves round bit zero
    localparam int GRD_W = SIG_W + 2;
    localparam int EXT_W = SIG_W + GRD_W;

    logic               sgn;
    logic [EXP_W-1:0]   ex;
    logic [MAN_W-1:0]   fr;
    logic [SIG_W-1:0]   sig;
    int                 unb;
    int                 sh;
    logic [EXT_W-1:0]   shr;
    logic [SIG_W-1:0]   kept;
    logic [INT_W-1:0]   mag;
    logic               grd;
    logic               stk;
    logic               up;

    always_comb begin
        sgn  = src[FP_W-1];
        ex   = src[FP_W-2 -: EXP_W];
        fr   = src[MAN_W-1:0];
        sig  = {(ex != '0), fr};
        unb  = (ex == '0) ? (1 - BIAS) : (int'(ex) - BIAS);
        sh   = 0;
        shr  = '0;
        kept = '0;
        mag  = '0;
        grd  = 1'b0;
        stk  = 1'b0;
        up   = 1'b0;
        res  = '0;
        inv  = 1'b0;
        inx  = 1'b0;
        if (&ex) begin
            // infinity or NaN
            inv = 1'b1;
            res = (sgn || (fr != '0)) ? INT_MOST_NEG : INT_MOST_POS;
        end else if (unb >= INT_W - 1) begin
            if (sgn && (unb == INT_W - 1) && (fr == '0)) begin
                res = INT_MOST_NEG;
            end else begin
                inv = 1'b1;
                res = sgn ? INT_MOST_NEG : INT_MOST_POS;
            end
        end else if (unb >= MAN_W) begin
            // integral, no fraction to drop
            mag = INT_W'(sig) << (unb - MAN_W);
            res = sgn ? (~mag + 1'b1) : mag;
        end else begin
            sh   = MAN_W - unb;
            if (sh > GRD_W) sh = GRD_W;
            shr  = {sig, {GRD_W{1'b0}}} >> sh;
            kept = shr[EXT_W-1:GRD_W];
            grd  = shr[GRD_W-1];
            stk  = |shr[GRD_W-2:0];
            unique case (rnd)
                RND_NEAR: up = grd & (stk | kept[0]);
                RND_ZERO: up = 1'b0;
                RND_UP:   up = (grd | stk) & ~sgn;
                RND_DOWN: up = (grd | stk) & sgn;
            endcase
            mag = INT_W'(kept) + INT_W'(up);
            res = sgn ? (~mag + 1'b1) : mag;
            inx = grd | stk;
        end
    end
endmodule

// File: rtl/fcu_i2f.sv
module fcu_i2f
    import fcu_pkg::*;
(
    input  logic [INT_W-1:0] src,
    output logic [FP_W-1:0]  res,
    output logic             inx
);
    // Normalised layout: leading one at the top, SIG_W kept bits, then guard, then sticky
    localparam int GRD_POS = INT_W - 1 - SIG_W;

    logic               sgn;
    logic [INT_W-1:0]   mag;
    logic [INT_W-1:0]   norm;
    int                 lead;
    logic [SIG_W-1:0]   sig;
    logic               grd;
    logic               stk;
    logic               up;
    logic [SIG_W:0]     sum;
    logic [EXP_W-1:0]   ex;

    always_comb begin
        sgn  = src[INT_W-1];
        mag  = sgn ? (~src + 1'b1) : src;
        lead = 0;
        for (int i = 0; i < INT_W; i++) begin
            if (mag[i]) lead = i;
        end
        norm = mag << (INT_W - 1 - lead);
        sig  = norm[INT_W-1 -: SIG_W];
        grd  = norm[GRD_POS];
        stk  = |norm[GRD_POS-1:0];
        up   = grd & (stk | sig[0]);
        sum  = {1'b0, sig} + (SIG_W+1)'(up);
        ex   = EXP_W'(lead + BIAS + int'(sum[SIG_W]));
        res  = '0;
        inx  = 1'b0;
        if (mag != '0) begin
            res = {sgn, ex, sum[MAN_W-1:0]};
            inx = grd | stk;
        end
    end
endmodule

// File: rtl/fcu_top.sv
module fcu_top
    import fcu_pkg::*;
#(
    parameter rnd_e DEFAULT_RND = RND_NEAR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] major,
    input  logic [CODE_W-1:0] minor,
    input  logic [INT_W-1:0]  operand,
    output logic [INT_W-1:0]  result,
    output logic              done,
    output logic              invalid,
    output logic              inexact
);
    cmd_t             cmd;
    logic [INT_W-1:0] f2i_res;
    logic             f2i_inv;
    logic             f2i_inx;
    logic [FP_W-1:0]  i2f_res;
    logic             i2f_inx;
    logic [INT_W-1:0] sel_res;
    logic             sel_inv;
    logic             sel_inx;
    fsm_e             st_q;
    fsm_e             st_d;

    fcu_decode #(.DEFAULT_RND(DEFAULT_RND)) u_dec (
        .major (major),
        .minor (minor),
        .cmd   (cmd)
    );

    fcu_f2i u_f2i (
        .src (operand),
        .rnd (cmd.rnd),
        .res (f2i_res),
        .inv (f2i_inv),
        .inx (f2i_inx)
    );

    fcu_i2f u_i2f (
        .src (operand),
        .res (i2f_res),
        .inx (i2f_inx)
    );

    always_comb begin
        sel_res = '0;
        sel_inv = 1'b0;
        sel_inx = 1'b0;
        unique case (cmd.op)
            OP_F2I: begin
                sel_res = f2i_res;
                sel_inv = f2i_inv;
                sel_inx = f2i_inx;
            end
            OP_I2F: begin
                sel_res = INT_W'(i2f_res);
                sel_inx = i2f_inx;
            end
            default: begin
                sel_res = '0;
            end
        endcase
    end

    // Next state: launch, chain, retire
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = start ? ST_DONE : ST_IDLE;
            ST_DONE: st_d = start ? ST_DONE : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result  <= '0;
            invalid <= 1'b0;
            inexact <= 1'b0;
        end else if (start) begin
            result  <= sel_res;
            invalid <= sel_inv;
            inexact <= sel_inx;
        end
    end

    assign done = (st_q == ST_DONE);
endmodule

// File: rtl/fcu_chk.sv
module fcu_chk
    import fcu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [CODE_W-1:0] major,
    input logic [CODE_W-1:0] minor,
    input logic [INT_W-1:0]  operand,
    input logic [INT_W-1:0]  result,
    input logic              done,
    input logic              invalid,
    input logic              inexact
);
    logic [2*CODE_W-1:0] pair;
    logic                legal;
    logic                is_f2i;
    logic                is_nan;

    assign pair   = {major, minor};
    assign is_f2i = (pair == PAIR_F2I_NEAR) || (pair == PAIR_F2I_ZERO) ||
                    (pair == PAIR_F2I_UP)   || (pair == PAIR_F2I_DOWN) ||
                    (pair == PAIR_F2I_DFLT);
    assign legal  = is_f2i || (pair == PAIR_I2F_DFLT);
    assign is_nan = (&operand[FP_W-2 -: EXP_W]) && (operand[MAN_W-1:0] != '0);

    // R1
    p_done_follows_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    p_done_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    // R4
    p_i2f_never_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && pair == PAIR_I2F_DFLT) |=> !invalid);
    // R6
    p_nan_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && is_f2i && is_nan) |=> (invalid && result == INT_MOST_NEG));
    // R7
    p_saturation_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> (result == INT_MOST_NEG || result == INT_MOST_POS));
    // R8
    p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> !inexact);
    // R9
    p_unsupported_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !legal) |=> (result == '0 && !invalid && !inexact));
    // R10
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(result) && $stable(invalid) && $stable(inexact)));
endmodule

bind fcu_top fcu_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .major   (major),
    .minor   (minor),
    .operand (operand),
    .result  (result),
    .done    (done),
    .invalid (invalid),
    .inexact (inexact)
);

// File: tb/sim_fcu_top.sv
`timescale 1ns/1ps
module sim_fcu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  major = 4'h0;
    logic [3:0]  minor = 4'h0;
    logic [31:0] operand = 32'h0;
    logic [31:0] result;
    logic        done;
    logic        invalid;
    logic        inexact;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    fcu_top u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .major   (major),
        .minor   (minor),
        .operand (operand),
        .result  (result),
        .done    (done),
        .invalid (invalid),
        .inexact (inexact)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Issue one operation, sample one cycle later away from the edge
    task automatic run_op(input string tag, input logic [3:0] mj, input logic [3:0] mn,
                          input logic [31:0] opd, input logic [31:0] exp_res,
                          input logic exp_inv, input logic exp_inx);
        @(negedge clk);
        major = mj; minor = mn; operand = opd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R1 done"}, 32'(done), 32'd1);
        chk({tag, " result"}, result, exp_res);
        chk({tag, " flags {inv,inx}"}, {30'd0, invalid, inexact}, {30'd0, exp_inv, exp_inx});
    endtask

    task automatic t_reset;
        chk("R11 done", 32'(done), 32'd0);
        chk("R11 result", result, 32'd0);
        chk("R11 flags", {30'd0, invalid, inexact}, 32'd0);
    endtask

    task automatic t_nearest;
        run_op("R2 near 2.5", 4'hC, 4'h0, 32'h40200000, 32'd2, 1'b0, 1'b1);
        run_op("R2 near 1.5", 4'hC, 4'h0, 32'h3FC00000, 32'd2, 1'b0, 1'b1);
        run_op("R2 near -2.5", 4'hC, 4'h0, 32'hC0200000, 32'hFFFFFFFE, 1'b0, 1'b1);
        run_op("R2 near 0.5", 4'hC, 4'h0, 32'h3F000000, 32'd0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R1 done low after pulse", 32'(done), 32'd0);
    endtask

    task automatic t_trunc;
        run_op("R2 trunc -1.5", 4'hD, 4'h0, 32'hBFC00000, 32'hFFFFFFFF, 1'b0, 1'b1);
        run_op("R2 trunc 2.5", 4'hD, 4'h0, 32'h40200000, 32'd2, 1'b0, 1'b1);
    endtask

    task automatic t_ceil;
        run_op("R2 ceil 1.5", 4'hE, 4'h0, 32'h3FC00000, 32'd2, 1'b0, 1'b1);
        run_op("R2 ceil -1.5", 4'hE, 4'h0, 32'hBFC00000, 32'hFFFFFFFF, 1'b0, 1'b1);
        run_op("R2 ceil 0.5", 4'hE, 4'h0, 32'h3F000000, 32'd1, 1'b0, 1'b1);
        run_op("R5 ceil min subnormal", 4'hE, 4'h0, 32'h00000001, 32'd1, 1'b0, 1'b1);
    endtask

    task automatic t_floor;
        run_op("R2 floor 1.5", 4'hF, 4'h0, 32'h3FC00000, 32'd1, 1'b0, 1'b1);
        run_op("R2 floor -1.5", 4'hF, 4'h0, 32'hBFC00000, 32'hFFFFFFFE, 1'b0, 1'b1);
        run_op("R2 floor -0.5", 4'hF, 4'h0, 32'hBF000000, 32'hFFFFFFFF, 1'b0, 1'b1);
    endtask

    task automatic t_default;
        run_op("R3 default 2.5", 4'h4, 4'h1, 32'h40200000, 32'd2, 1'b0, 1'b1);
        run_op("R3 default 3.5", 4'h4, 4'h1, 32'h40600000, 32'd4, 1'b0, 1'b1);
    endtask

    task automatic t_exact;
        run_op("R5 R8 100.0", 4'hC, 4'h0, 32'h42C80000, 32'd100, 1'b0, 1'b0);
        run_op("R5 2^30", 4'hD, 4'h0, 32'h4E800000, 32'h40000000, 1'b0, 1'b0);
        run_op("R5 +0.0", 4'hC, 4'h0, 32'h00000000, 32'd0, 1'b0, 1'b0);
        run_op("R5 -0.0", 4'hF, 4'h0, 32'h80000000, 32'd0, 1'b0, 1'b0);
        run_op("R5 R8 near min subnormal", 4'hC, 4'h0, 32'h00000001, 32'd0, 1'b0, 1'b1);
    endtask

    task automatic t_saturate;
        run_op("R7 +2^31", 4'hC, 4'h0, 32'h4F000000, 32'h7FFFFFFF, 1'b1, 1'b0);
        run_op("R7 -2^31 exact", 4'hD, 4'h0, 32'hCF000000, 32'h80000000, 1'b0, 1'b0);
        run_op("R7 -2^32", 4'hD, 4'h0, 32'hCF800000, 32'h80000000, 1'b1, 1'b0);
        run_op("R7 +inf", 4'hE, 4'h0, 32'h7F800000, 32'h7FFFFFFF, 1'b1, 1'b0);
        run_op("R7 -inf", 4'hF, 4'h0, 32'hFF800000, 32'h80000000, 1'b1, 1'b0);
    endtask

    task automatic t_nan;
        run_op("R6 +NaN", 4'hC, 4'h0, 32'h7FC00000, 32'h80000000, 1'b1, 1'b0);
        run_op("R6 -NaN", 4'h4, 4'h1, 32'hFFC00001, 32'h80000000, 1'b1, 1'b0);
    endtask

    task automatic t_i2f;
        run_op("R4 zero", 4'h0, 4'h9, 32'd0, 32'h00000000, 1'b0, 1'b0);
        run_op("R4 one", 4'h0, 4'h9, 32'd1, 32'h3F800000, 1'b0, 1'b0);
        run_op("R4 minus one", 4'h0, 4'h9, 32'hFFFFFFFF, 32'hBF800000, 1'b0, 1'b0);
        run_op("R4 2^24", 4'h0, 4'h9, 32'h01000000, 32'h4B800000, 1'b0, 1'b0);
        run_op("R4 tie to even down", 4'h0, 4'h9, 32'h01000001, 32'h4B800000, 1'b0, 1'b1);
        run_op("R4 tie to even up", 4'h0, 4'h9, 32'h01000003, 32'h4B800002, 1'b0, 1'b1);
        run_op("R4 most negative", 4'h0, 4'h9, 32'h80000000, 32'hCF000000, 1'b0, 1'b0);
        run_op("R4 most positive", 4'h0, 4'h9, 32'h7FFFFFFF, 32'h4F000000, 1'b0, 1'b1);
    endtask

    task automatic t_unsupported;
        run_op("R8 setup flags", 4'hC, 4'h0, 32'h7FC00000, 32'h80000000, 1'b1, 1'b0);
        run_op("R9 C/1", 4'hC, 4'h1, 32'h3FC00000, 32'd0, 1'b0, 1'b0);
        run_op("R9 4/0", 4'h4, 4'h0, 32'h40200000, 32'd0, 1'b0, 1'b0);
        run_op("R9 0/0", 4'h0, 4'h0, 32'h00000005, 32'd0, 1'b0, 1'b0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        major = 4'hC; minor = 4'h0; operand = 32'h40200000; start = 1'b1;
        @(negedge clk);
        chk("R1 chain #1 done", 32'(done), 32'd1);
        chk("R2 chain #1 result", result, 32'd2);
        chk("R8 chain #1 flags", {30'd0, invalid, inexact}, 32'd1);
        major = 4'h0; minor = 4'h9; operand = 32'h01000003;
        @(negedge clk);
        chk("R1 chain #2 done", 32'(done), 32'd1);
        chk("R4 chain #2 result", result, 32'h4B800002);
        chk("R8 chain #2 flags", {30'd0, invalid, inexact}, 32'd1);
        major = 4'h7; minor = 4'h7; operand = 32'h7FC00000;
        @(negedge clk);
        start = 1'b0;
        chk("R1 chain #3 done", 32'(done), 32'd1);
        chk("R9 chain #3 result", result, 32'd0);
        chk("R9 chain #3 flags", {30'd0, invalid, inexact}, 32'd0);
        @(negedge clk);
        chk("R1 chain retire", 32'(done), 32'd0);
    endtask

    task automatic t_hold;
        run_op("R10 seed", 4'hE, 4'h0, 32'h7F800000, 32'h7FFFFFFF, 1'b1, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            major = 4'(k); minor = 4'h9; operand = 32'h12345678 + 32'(k);
            @(negedge clk);
            chk("R10 held result", result, 32'h7FFFFFFF);
            chk("R10 held flags", {30'd0, invalid, inexact}, 32'd2);
            chk("R10 done stays low", 32'(done), 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nearest();
        t_trunc();
        t_ceil();
        t_floor();
        t_default();
        t_exact();
        t_saturate();
        t_nan();
        t_i2f();
        t_unsupported();
        t_back_to_back();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule